// File: doc/BRIEF.md
# Multi-channel PWM generator

This block drives several pulse-width modulated outputs from one shared timebase. A prescaled phase counter runs while a run bit is set. A divider sets how many clock cycles each phase step lasts. A resolution setting sets how many phase steps make up one PWM period. Each channel compares the shared phase, shifted back by its own phase delay, against a duty value. It drives its output bit high while the shifted phase is below that duty value.

A channel has three modes. In pulse mode it holds one fixed duty value. In blink mode it switches between two duty values on period counts. In heartbeat mode it moves its duty value back and forth between two endpoints in fixed increments. An invert bit flips the polarity of each output on its own. Channels are configured through a single-cycle write port and enabled by a mask. While a channel is enabled, its settings cannot change. While the timebase is running, the timing settings cannot change.

Top module: `pwm_multi_gen`

## Requirements
- R1: While run is set, the phase advances by one step every clk_div+1 clock cycles, so each phase step lasts clk_div+1 cycles at the output.
- R2: While run is clear, the phase and the prescaler are held at zero, so every enabled channel outputs the value it has for phase zero.
- R3: With resolution n (0..15), a PWM period has 2^(n+1) phase steps, and duty, delay and phase are compared only in their top n+1 bits of 16. A duty of 16'hFFFF therefore gives 2^(n+1)-1 high steps per period.
- R4: In pulse mode (blink bit clear, with the heartbeat bit ignored), a channel's raw output is high when ((phase - delay) masked) < (A masked). The output pin shows this one clock after the phase value it was computed from.
- R5: In blink mode (blink set, heartbeat clear), the channel uses A for X+1 periods, then B for Y+1 periods, and repeats. A may be greater than, less than or equal to B.
- R6: In heartbeat mode (blink and heartbeat both set), the duty starts at A. Every X+1 periods it moves Y+1 toward B. When a step reaches or passes an endpoint, the duty is clamped to that endpoint and the direction reverses. This holds for A<B, A>B and A=B.
- R7: A channel's phase delay delays its waveform by that many masked phase steps, modulo the period. Each channel has its own delay.
- R8: The pin equals the raw output XOR the channel's invert bit. A disabled channel's raw output is low, so a disabled channel shows its invert bit.
- R9: Each channel has its own enable. A disabled channel keeps its blink and heartbeat sequence at its start point (A, toward B), so every enable starts a new sequence.
- R10: Writes to the duty, blink or mode settings of an enabled channel are ignored.
- R11: While run is set, a timing write changes only the run bit; the divider and resolution fields are ignored.
- R12: After reset, all outputs are low, the timebase is stopped, no channel is enabled and all settings are zero.
- R13: Writes take effect in the cycle after cfg_we_i. cfg_addr_i selects the setting:
  - 0, timing: bit 0 is run, bits 11:8 are the resolution, bits 31:16 are clk_div.
  - 1, enable mask: bit i enables channel i.
  - 2, duty: bits 15:0 are A, bits 31:16 are B.
  - 3, blink: bits 15:0 are X, bits 31:16 are Y.
  - 4, mode: bits 15:0 are the delay, bit 29 is invert, bit 30 is heartbeat, bit 31 is blink.
  Addresses 2 to 4 go to the channel on cfg_ch_i. A channel index past the last channel is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we_i | input | 1 | Setting write strobe |
| cfg_addr_i | input | 3 | Setting select |
| cfg_ch_i | input | CH_W (2) | Target channel for per-channel settings |
| cfg_wdata_i | input | 32 | Write data |
| pwm_o | output | NCH (3) | One PWM output per channel |

## Verification
The bench counts high steps in each period, aligned to a reference channel with a one-step duty. This exposes off-by-one period counting in blink mode: holding A for X periods instead of X+1 shifts the pattern. In heartbeat mode, a step that overshoots an endpoint must be clamped and reverse direction. A design that reverses without clamping, or that wraps its arithmetic, gives a wrong duty sequence. Descending (A>B) and flat (A=B) sweeps are also covered. The bench compares the phase-delay windows against each other, including one that wraps through the period end. A missing modulo shows up as a lost pulse. Finally, the bench writes to a locked channel and to locked timing settings while the block runs, and writes to a channel index that does not exist. A design that lets any of these through changes the pulse lengths it measures.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int unsigned FIELD_W = 16;

  typedef enum logic [2:0] {
    ADDR_TIMING = 3'd0,
    ADDR_CHEN   = 3'd1,
    ADDR_DUTY   = 3'd2,
    ADDR_BLINK  = 3'd3,
    ADDR_MODE   = 3'd4
  } cfg_addr_e;

  typedef struct packed {
    logic [FIELD_W-1:0] duty_a;
    logic [FIELD_W-1:0] duty_b;
    logic [FIELD_W-1:0] hold_x;
    logic [FIELD_W-1:0] step_y;
    logic [FIELD_W-1:0] delay;
    logic               blink_en;
    logic               beat_en;
    logic               invert;
  } chan_cfg_t;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned RESN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [RESN_W-1:0] resn_i,
  output logic [CNT_W-1:0]  phase_o,
  output logic [CNT_W-1:0]  mask_o,
  output logic              period_end_o
);

  localparam logic [RESN_W-1:0] RESN_MAX = RESN_W'(CNT_W - 1);

  logic [RESN_W-1:0] resn_eff;
  logic [RESN_W-1:0] shamt;
  logic [CNT_W-1:0]  step;
  logic [CNT_W-1:0]  phase_q, phase_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CNT_W:0]    sum;
  logic              tick;

  always_comb begin
    resn_eff = (resn_i > RESN_MAX) ? RESN_MAX : resn_i;
    shamt    = RESN_MAX - resn_eff;
    step     = CNT_W'(1) << shamt;
    tick     = run_i && (div_q == div_i);
    sum      = {1'b0, phase_q} + {1'b0, step};
    div_d    = div_q;
    phase_d  = phase_q;
    if (!run_i) begin
      div_d   = '0;
      phase_d = '0;
    end else if (tick) begin
      div_d   = '0;
      phase_d = sum[CNT_W-1:0];
    end else begin
      div_d   = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      phase_q <= '0;
    end else begin
      div_q   <= div_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o      = phase_q;
  assign mask_o       = ~(step - 1'b1);
  assign period_end_o = tick && sum[CNT_W];

  // R1: prescaler never runs past the programmed divider
  p_div_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (div_q <= div_i));

  // R2: stopping the timebase parks it at zero
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (phase_q == '0 && div_q == '0));

  // R3: phase stays on the grid of the selected resolution
  p_phase_grid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> ((phase_q & ~mask_o) == '0));

endmodule

// File: rtl/pwm_duty_seq.sv
module pwm_duty_seq
  import pwm_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               period_end_i,
  input  chan_cfg_t          cfg_i,
  output logic [FIELD_W-1:0] duty_o
);

  localparam int unsigned W = FIELD_W;

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] cur_q, cur_d;
  logic         sel_b_q, sel_b_d;
  logic         toward_b_q, toward_b_d;

  logic [W:0]   inc, up_sum, dn_sum;
  logic [W-1:0] target, hold_lim;
  logic         a_le_b, going_up, hit;

  always_comb begin
    a_le_b   = (cfg_i.duty_a <= cfg_i.duty_b);
    inc      = {1'b0, cfg_i.step_y} + {{W{1'b0}}, 1'b1};
    up_sum   = {1'b0, cur_q} + inc;
    dn_sum   = {1'b0, cur_q} - inc;
    target   = toward_b_q ? cfg_i.duty_b : cfg_i.duty_a;
    going_up = (toward_b_q == a_le_b);
    hit      = going_up ? (up_sum >= {1'b0, target})
                        : (dn_sum[W] || (dn_sum[W-1:0] <= target));
    hold_lim = sel_b_q ? cfg_i.step_y : cfg_i.hold_x;

    cnt_d      = cnt_q;
    cur_d      = cur_q;
    sel_b_d    = sel_b_q;
    toward_b_d = toward_b_q;

    if (!en_i) begin
      cnt_d      = '0;
      cur_d      = cfg_i.duty_a;
      sel_b_d    = 1'b0;
      toward_b_d = 1'b1;
    end else if (period_end_i && cfg_i.blink_en) begin
      if (!cfg_i.beat_en) begin
        if (cnt_q == hold_lim) begin
          cnt_d   = '0;
          sel_b_d = !sel_b_q;
        end else begin
          cnt_d   = cnt_q + 1'b1;
        end
      end else if (cnt_q == cfg_i.hold_x) begin
        cnt_d = '0;
        if (hit) begin
          cur_d      = target;
          toward_b_d = !toward_b_q;
        end else begin
          cur_d      = going_up ? up_sum[W-1:0] : dn_sum[W-1:0];
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      cur_q      <= '0;
      sel_b_q    <= 1'b0;
      toward_b_q <= 1'b1;
    end else begin
      cnt_q      <= cnt_d;
      cur_q      <= cur_d;
      sel_b_q    <= sel_b_d;
      toward_b_q <= toward_b_d;
    end
  end

  always_comb begin
    if (!cfg_i.blink_en)     duty_o = cfg_i.duty_a;
    else if (!cfg_i.beat_en) duty_o = sel_b_q ? cfg_i.duty_b : cfg_i.duty_a;
    else                     duty_o = cur_q;
  end

  // R5: the duty in use only moves on a period boundary
  p_duty_steady_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !period_end_i) |=> $stable(duty_o));

  // R6: the sweep never leaves the span between its endpoints
  p_beat_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cfg_i.blink_en && cfg_i.beat_en) |->
      ((cur_q >= (a_le_b ? cfg_i.duty_a : cfg_i.duty_b)) &&
       (cur_q <= (a_le_b ? cfg_i.duty_b : cfg_i.duty_a))));

endmodule

// File: rtl/pwm_chan_out.sv
module pwm_chan_out #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] phase_i,
  input  logic [CNT_W-1:0] mask_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             invert_i,
  output logic             out_o
);

  logic [CNT_W-1:0] rel;
  logic             hit;
  logic             out_q, out_d;

  always_comb begin
    rel   = phase_i - (delay_i & mask_i);
    hit   = en_i && ((rel & mask_i) < (duty_i & mask_i));
    out_d = hit ^ invert_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  // R8: a disabled channel rests at its polarity level
  p_off_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (out_o == $past(invert_i)));

  // R4: a zero masked duty never produces an active pulse
  p_zero_duty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ((duty_i & mask_i) == '0)) |=> (out_o == $past(invert_i)));

endmodule

// File: rtl/pwm_multi_gen.sv
module pwm_multi_gen
  import pwm_pkg::*;
#(
  parameter int unsigned NCH    = 3,
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned RESN_W = 4,
  parameter int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [2:0]      cfg_addr_i,
  input  logic [CH_W-1:0] cfg_ch_i,
  input  logic [31:0]     cfg_wdata_i,
  output logic [NCH-1:0]  pwm_o
);

  localparam int unsigned CNT_W = FIELD_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // setting registers
  logic              run_q, run_d;
  logic [RESN_W-1:0] resn_q, resn_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [NCH-1:0]    en_q, en_d;
  chan_cfg_t         cfg_q [NCH];
  chan_cfg_t         cfg_d [NCH];

  always_comb begin
    run_d  = run_q;
    resn_d = resn_q;
    div_d  = div_q;
    en_d   = en_q;
    cfg_d  = cfg_q;
    if (cfg_we_i) begin
      case (cfg_addr_i)
        ADDR_TIMING: begin
          run_d = cfg_wdata_i[0];
          if (!run_q) begin
            resn_d = cfg_wdata_i[8 +: RESN_W];
            div_d  = cfg_wdata_i[16 +: DIV_W];
          end
        end
        ADDR_CHEN: en_d = cfg_wdata_i[NCH-1:0];
        default: begin
          for (int c = 0; c < NCH; c++) begin
            if (cfg_ch_i == CH_W'(c) && !en_q[c]) begin
              case (cfg_addr_i)
                ADDR_DUTY: begin
                  cfg_d[c].duty_a = cfg_wdata_i[0 +: CNT_W];
                  cfg_d[c].duty_b = cfg_wdata_i[16 +: CNT_W];
                end
                ADDR_BLINK: begin
                  cfg_d[c].hold_x = cfg_wdata_i[0 +: CNT_W];
                  cfg_d[c].step_y = cfg_wdata_i[16 +: CNT_W];
                end
                ADDR_MODE: begin
                  cfg_d[c].delay    = cfg_wdata_i[0 +: CNT_W];
                  cfg_d[c].invert   = cfg_wdata_i[29];
                  cfg_d[c].beat_en  = cfg_wdata_i[30];
                  cfg_d[c].blink_en = cfg_wdata_i[31];
                end
                default: ;
              endcase
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      resn_q <= '0;
      div_q  <= '0;
      en_q   <= '0;
      for (int c = 0; c < NCH; c++) cfg_q[c] <= '0;
    end else begin
      run_q  <= run_d;
      resn_q <= resn_d;
      div_q  <= div_d;
      en_q   <= en_d;
      cfg_q  <= cfg_d;
    end
  end

  // shared timebase
  logic [CNT_W-1:0] phase, mask;
  logic             period_end;

  pwm_timebase #(
    .CNT_W (CNT_W),
    .DIV_W (DIV_W),
    .RESN_W(RESN_W)
  ) u_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .run_i       (run_q),
    .div_i       (div_q),
    .resn_i      (resn_q),
    .phase_o     (phase),
    .mask_o      (mask),
    .period_end_o(period_end)
  );

  // channels
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [CNT_W-1:0] duty;

    pwm_duty_seq u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_n),
      .en_i        (en_q[c]),
      .period_end_i(period_end),
      .cfg_i       (cfg_q[c]),
      .duty_o      (duty)
    );

    pwm_chan_out #(
      .CNT_W(CNT_W)
    ) u_out (
      .clk_i   (clk_i),
      .rst_ni  (rst_n),
      .en_i    (en_q[c]),
      .phase_i (phase),
      .mask_i  (mask),
      .delay_i (cfg_q[c].delay),
      .duty_i  (duty),
      .invert_i(cfg_q[c].invert),
      .out_o   (pwm_o[c])
    );

    // R10: an enabled channel's settings are frozen
    p_cfg_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
      en_q[c] |=> $stable(cfg_q[c]));
  end

  // R11: timing fields are frozen while the timebase runs
  p_timing_locked_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    run_q |=> ($stable(resn_q) && $stable(div_q)));

endmodule

// File: tb/pwm_multi_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_multi_gen_tb_top;

  localparam int NCH = 3;
  localparam logic [15:0] U = 16'h2000;  // one step at resolution 2

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [1:0]  cfg_ch;
  logic [31:0] cfg_wdata;
  logic [NCH-1:0] pwm;

  logic [NCH-1:0] hist [256];
  int n_chk;
  int n_fail;
  bit done;

  pwm_multi_gen dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .cfg_we_i   (cfg_we),
    .cfg_addr_i (cfg_addr),
    .cfg_ch_i   (cfg_ch),
    .cfg_wdata_i(cfg_wdata),
    .pwm_o      (pwm)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int ch, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_ch = 2'(ch); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic timing(input bit run, input logic [3:0] resn, input logic [15:0] div);
    wr(3'd0, 0, {div, 4'h0, resn, 7'h0, run});
  endtask

  task automatic set_en(input logic [2:0] m);
    wr(3'd1, 0, {29'h0, m});
  endtask

  task automatic set_chan(input int ch, input logic [15:0] a, input logic [15:0] b,
                          input logic [15:0] x, input logic [15:0] y, input logic [15:0] d,
                          input bit inv, input bit hb, input bit bl);
    wr(3'd2, ch, {b, a});
    wr(3'd3, ch, {y, x});
    wr(3'd4, ch, {bl, hb, inv, 13'h0, d});
  endtask

  task automatic cap(input logic [3:0] resn, input logic [15:0] div, input int n);
    timing(1'b1, resn, div);
    hist[0] = pwm;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      hist[i] = pwm;
    end
    timing(1'b0, resn, div);
  endtask

  function automatic int cnt_hi(input int ch, input int st, input int len);
    int s = 0;
    for (int i = st; i < st + len; i++) s += int'(hist[i][ch]);
    return s;
  endfunction

  function automatic int max_run(input int ch, input int st, input int n);
    int best = 0;
    int cur = 0;
    for (int i = st; i < n; i++) begin
      if (hist[i][ch]) cur++; else cur = 0;
      if (cur > best) best = cur;
    end
    return best;
  endfunction

  function automatic int find_start();
    for (int i = 1; i < 256; i++) if (hist[i][2]) return i;
    return 1;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R12 outputs low after reset", int'(pwm), 0);
  endtask

  task automatic t_pulse();
    int s;
    set_en(3'b000);
    set_chan(2, U, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    set_chan(0, 3*U, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    set_chan(1, 5*U, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    set_en(3'b101);
    cap(4'd2, 16'd0, 64);
    s = find_start();
    for (int p = 0; p < 5; p++)
      chk($sformatf("R4 pulse highs in period %0d", p), cnt_hi(0, s + 8*p, 8), 3);
    chk("R9 channel left disabled stays low", cnt_hi(1, 0, 64), 0);
    chk("R1 run length with divider 0", max_run(0, s, 64), 3);
    cap(4'd2, 16'd2, 120);
    s = find_start();
    for (int p = 0; p < 4; p++)
      chk($sformatf("R1 divider 2 highs in period %0d", p), cnt_hi(0, s + 24*p, 24), 9);
    chk("R1 run length with divider 2", max_run(0, s, 120), 9);
    cap(4'd3, 16'd0, 70);
    s = find_start();
    for (int p = 0; p < 3; p++)
      chk($sformatf("R3 resolution 3 highs in period %0d", p), cnt_hi(0, s + 16*p, 16), 6);
    chk("R3 run length at resolution 3", max_run(0, s, 70), 6);
  endtask

  task automatic t_bounds();
    int s;
    int hold;
    set_en(3'b100);
    set_chan(0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    set_en(3'b101);
    cap(4'd2, 16'd0, 40);
    chk("R4 zero duty never high", cnt_hi(0, 1, 39), 0);
    set_en(3'b100);
    set_chan(0, 16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    set_en(3'b101);
    cap(4'd2, 16'd0, 40);
    s = find_start();
    for (int p = 0; p < 3; p++)
      chk($sformatf("R3 full duty highs in period %0d", p), cnt_hi(0, s + 8*p, 8), 7);
    repeat (3) @(negedge clk);
    hold = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      hold += int'(pwm[2]);
    end
    chk("R2 stopped timebase parks at phase zero", hold, 16);
  endtask

  task automatic t_delay_invert();
    int mism;
    set_en(3'b000);
    set_chan(0, 3*U, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    set_chan(1, 3*U, 16'h0, 16'h0, 16'h0, 2*U, 1'b0, 1'b0, 1'b0);
    set_chan(2, 3*U, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0);
    set_en(3'b111);
    cap(4'd2, 16'd0, 48);
    mism = 0;
    for (int i = 3; i < 48; i++) if (hist[i][1] != hist[i-2][0]) mism++;
    chk("R7 delay of two steps mismatches", mism, 0);
    mism = 0;
    for (int i = 0; i < 48; i++) if (hist[i][2] == hist[i][0]) mism++;
    chk("R8 inverted channel mismatches", mism, 0);
    set_en(3'b101);
    set_chan(1, 3*U, 16'h0, 16'h0, 16'h0, 6*U, 1'b0, 1'b0, 1'b0);
    set_en(3'b111);
    cap(4'd2, 16'd0, 48);
    mism = 0;
    for (int i = 7; i < 48; i++) if (hist[i][1] != hist[i-6][0]) mism++;
    chk("R7 wrapping delay mismatches", mism, 0);
    set_en(3'b011);
    repeat (3) @(negedge clk);
    chk("R8 disabled inverted channel level", int'(pwm[2]), 1);
  endtask

  task automatic t_blink();
    int s;
    set_en(3'b000);
    set_chan(2, U, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    set_chan(0, 2*U, 5*U, 16'd1, 16'd0, 16'h0, 1'b0, 1'b0, 1'b1);
    set_en(3'b101);
    cap(4'd2, 16'd0, 56);
    s = find_start();
    for (int p = 0; p < 6; p++)
      chk($sformatf("R5 blink A<B period %0d", p), cnt_hi(0, s + 8*p, 8), (p % 3 < 2) ? 2 : 5);
    set_en(3'b100);
    set_chan(0, 6*U, U, 16'd0, 16'd2, 16'h0, 1'b0, 1'b0, 1'b1);
    set_en(3'b101);
    cap(4'd2, 16'd0, 56);
    s = find_start();
    for (int p = 0; p < 6; p++)
      chk($sformatf("R5 R9 blink A>B after re-enable period %0d", p),
          cnt_hi(0, s + 8*p, 8), (p % 4 == 0) ? 6 : 1);
  endtask

  task automatic hb_case(input string tag, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] x, input logic [15:0] y, input bit bl,
                         input logic [39:0] seq);
    int s;
    set_en(3'b100);
    set_chan(0, a, b, x, y, 16'h0, 1'b0, 1'b1, bl);
    set_en(3'b101);
    cap(4'd2, 16'd0, 88);
    s = find_start();
    for (int p = 0; p < 10; p++)
      chk($sformatf("%s period %0d", tag, p), cnt_hi(0, s + 8*p, 8), int'(seq[4*(9-p) +: 4]));
  endtask

  task automatic t_heartbeat();
    set_en(3'b000);
    set_chan(2, U, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    hb_case("R6 rising sweep", U, 4*U, 16'd0, U - 16'd1, 1'b1, 40'h1234321234);
    hb_case("R6 falling sweep held two periods", 4*U, U, 16'd1, U - 16'd1, 1'b1, 40'h4433221122);
    hb_case("R6 overshoot clamps", U, 4*U, 16'd0, 2*U - 16'd1, 1'b1, 40'h1342134213);
    hb_case("R6 equal endpoints", 3*U, 3*U, 16'd0, U - 16'd1, 1'b1, 40'h3333333333);
    hb_case("R4 heartbeat bit alone is pulse mode", 2*U, 5*U, 16'd0, U - 16'd1, 1'b0, 40'h2222222222);
  endtask

  task automatic t_lock();
    int s;
    set_en(3'b000);
    set_chan(2, U, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    set_chan(0, 3*U, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0);
    wr(3'd2, 3, {16'h0, 6*U});
    set_en(3'b101);
    wr(3'd2, 0, {16'h0, 6*U});
    timing(1'b1, 4'd2, 16'd0);
    timing(1'b1, 4'd3, 16'd0);
    hist[0] = pwm;
    for (int i = 1; i < 48; i++) begin
      @(negedge clk);
      hist[i] = pwm;
    end
    timing(1'b0, 4'd2, 16'd0);
    s = 0;
    for (int i = 1; i < 40; i++) if (s == 0 && hist[i][2] && !hist[i-1][2]) s = i;
    chk("R13 write to missing channel ignored", cnt_hi(0, s, 8), 3);
    chk("R10 locked duty write ignored", cnt_hi(0, s + 8, 8), 3);
    chk("R11 resolution write while running ignored", max_run(0, s, 48), 3);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_ch = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pulse();
    t_bounds();
    t_delay_invert();
    t_blink();
    t_heartbeat();
    t_lock();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-timebase actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule